// File: doc/BRIEF.md
# Tape Record Stream Framer

This block sits between a byte-oriented record source or sink and a serial medium that stores variable-length records. Its write half collects one record from a valid/ready byte input whose last byte is flagged. Once the record is complete, the write half sends it out as a framed byte stream. The frame is a 32-bit length word, then the payload, then a zero filler byte when the length is odd, then the length word a second time. On command, the write half instead sends a file mark, which is one length word of zero with nothing after it.

The read half parses a framed stream of the same shape. It hands the payload bytes on with a flag on the final byte of each record, and it drops the filler byte and both length words. It pulses an indication for every file mark, and a second indication when a file mark comes straight after another one, which marks the end of recorded data. It pulses a framing error when the trailing length word of a record differs from the leading one. Because the length is stored at both ends of a record, a medium driver can skip over records in either direction without reading the payload.

Length words are carried least-significant byte first. The largest record the write half can hold is set by a parameter, up to 65536 bytes.

Top module: `tape_rec_framer`

## Requirements
- R1: After reset the write input is ready and the file-mark command is ready. The stream output carries no valid byte, the parser input is ready, no payload is offered, and markSeen, eotSeen and frameErr are low.
- R2: A record of N bytes (1 <= N <= MAX_BYTES) is emitted on txData in this order: N as four bytes with the least-significant byte first, then the N payload bytes in arrival order, then N again as four bytes with the least-significant byte first.
- R3: When N is odd, exactly one byte of value 0x00 is emitted between the last payload byte and the trailing length word. When N is even, no byte is inserted there.
- R4: An accepted file-mark command emits exactly four 0x00 bytes and nothing else. markReady is high only when no record byte is buffered and wrValid is low, so a record byte offered in the same cycle takes priority.
- R5: wrReady is low from the cycle after a record's last byte is accepted until its trailing length word has been emitted, and it is also low while a file mark is being emitted. A byte offered in that window is not taken.
- R6: The parser forwards each payload byte exactly once and in order on outData. outLast is high only on the final byte of the record. Length words and the filler byte never appear on the output, and the filler byte is dropped whatever its value.
- R7: frameErr pulses high for one cycle, in the cycle after the last trailing length byte is accepted, when the trailing length differs from the leading length. It stays low for records whose two lengths match.
- R8: A length word of zero on the parser input pulses markSeen for one cycle, in the cycle after its fourth byte is accepted, and delivers no payload.
- R9: eotSeen pulses together with markSeen when the item just before the file mark was also a file mark. After a record it stays low.
- R10: While payload is being delivered, rxReady follows outReady, so a byte held on rxData is neither lost nor duplicated while outReady is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrData | input | 8 | Record byte to be framed |
| wrValid | input | 1 | wrData is valid |
| wrLast | input | 1 | wrData is the final byte of its record |
| wrReady | output | 1 | Write side accepts a byte |
| markValid | input | 1 | Request to emit a file mark |
| markReady | output | 1 | File-mark request is accepted |
| txData | output | 8 | Framed stream byte |
| txValid | output | 1 | txData is valid |
| txReady | input | 1 | Downstream takes txData |
| rxData | input | 8 | Framed stream byte to parse |
| rxValid | input | 1 | rxData is valid |
| rxReady | output | 1 | Parser takes rxData |
| outData | output | 8 | Recovered payload byte |
| outValid | output | 1 | outData is valid |
| outLast | output | 1 | outData is the final payload byte of its record |
| outReady | input | 1 | Consumer takes outData |
| markSeen | output | 1 | One-cycle pulse per parsed file mark |
| eotSeen | output | 1 | One-cycle pulse for a file mark that follows a file mark |
| frameErr | output | 1 | One-cycle pulse on a length mismatch |

## Verification
The bench builds the block with MAX_BYTES set to 16. With that value, records at the full buffer size sit beside one-byte, odd and even records in a short run, and random lengths cover the whole legal range many times over. The small depth also keeps every length word to a single nonzero low byte, so the other three bytes exercise the little-endian ordering with zeros. Random stalls on txReady and outReady put pressure on the handshakes in every framing phase.

// File: rtl/tapefr_pkg.sv
`timescale 1ns/1ps
package tapefr_pkg;
  typedef enum logic [2:0] {W_FILL, W_HEAD, W_BODY, W_PAD, W_TAIL, W_MARK} wrState_e;
  typedef enum logic [1:0] {R_HEAD, R_BODY, R_PAD, R_TAIL} rdState_e;
  typedef enum logic [1:0] {SRC_LEN, SRC_BUF, SRC_ZERO} txSrc_e;

  // control -> datapath, write half
  typedef struct packed {
    logic   store;
    logic   fillClr;
    logic   idxInc;
    logic   idxClr;
    txSrc_e src;
  } wrStrobe_t;

  // control -> datapath, read half
  typedef struct packed {
    logic shift;
    logic cntClr;
    logic loadLen;
    logic remDec;
    logic markHit;
    logic tailChk;
  } rdStrobe_t;

  typedef struct packed {
    logic full;
    logic empty;
    logic idxLast4;
    logic bodyLast;
    logic oddLen;
  } wrStatus_t;

  typedef struct packed {
    logic cntLast4;
    logic wordZero;
    logic remOne;
    logic leadOdd;
  } rdStatus_t;
endpackage

// File: rtl/tapefr_dp.sv
`timescale 1ns/1ps
module tapefr_dp
  import tapefr_pkg::*;
#(
  parameter int MAX_BYTES = 2048
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] wrData,
  input  wrStrobe_t  wrS,
  output wrStatus_t  wrSt,
  output logic [7:0] txData,
  input  logic [7:0] rxData,
  input  rdStrobe_t  rdS,
  output rdStatus_t  rdSt,
  output logic       markSeen,
  output logic       eotSeen,
  output logic       frameErr
);
  localparam int CNT_W  = $clog2(MAX_BYTES + 1);
  localparam int ADDR_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam int IDX_W  = (CNT_W < 2) ? 2 : CNT_W;

  // ---------------- write half ----------------
  logic [7:0]       bufMem [MAX_BYTES];
  logic [CNT_W-1:0] fillCnt;
  logic [IDX_W-1:0] idx;
  logic [31:0]      lenWord;
  logic [7:0]       lenByte;
  logic [7:0]       bufByte;

  always_ff @(posedge clk) begin
    if (wrS.store) bufMem[fillCnt[ADDR_W-1:0]] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt <= '0;
      idx     <= '0;
    end else begin
      if (wrS.fillClr)    fillCnt <= '0;
      else if (wrS.store) fillCnt <= fillCnt + 1'b1;
      if (wrS.idxClr)      idx <= '0;
      else if (wrS.idxInc) idx <= idx + 1'b1;
    end
  end

  assign lenWord = {{(32-CNT_W){1'b0}}, fillCnt};
  assign lenByte = lenWord[{idx[1:0], 3'b000} +: 8];
  assign bufByte = bufMem[idx[ADDR_W-1:0]];

  always_comb begin
    case (wrS.src)
      SRC_LEN: txData = lenByte;
      SRC_BUF: txData = bufByte;
      default: txData = 8'h00;
    endcase
  end

  assign wrSt.full     = (fillCnt == CNT_W'(MAX_BYTES));
  assign wrSt.empty    = (fillCnt == '0);
  assign wrSt.idxLast4 = (idx == IDX_W'(3));
  assign wrSt.bodyLast = (idx == (IDX_W'(fillCnt) - IDX_W'(1)));
  assign wrSt.oddLen   = fillCnt[0];

  // ---------------- read half ----------------
  logic [23:0] hdrSh;
  logic [31:0] wordNext;
  logic [1:0]  rdCnt;
  logic [31:0] leadLen;
  logic [31:0] rem;
  logic        lastMark;

  assign wordNext = {rxData, hdrSh};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrSh    <= '0;
      rdCnt    <= '0;
      leadLen  <= '0;
      rem      <= '0;
      lastMark <= 1'b0;
      markSeen <= 1'b0;
      eotSeen  <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      markSeen <= 1'b0;
      eotSeen  <= 1'b0;
      frameErr <= 1'b0;
      if (rdS.shift) hdrSh <= wordNext[31:8];
      if (rdS.cntClr)     rdCnt <= '0;
      else if (rdS.shift) rdCnt <= rdCnt + 2'd1;
      if (rdS.loadLen) begin
        leadLen  <= wordNext;
        rem      <= wordNext;
        lastMark <= 1'b0;
      end else if (rdS.remDec) begin
        rem <= rem - 32'd1;
      end
      if (rdS.markHit) begin
        markSeen <= 1'b1;
        eotSeen  <= lastMark;
        lastMark <= 1'b1;
      end
      if (rdS.tailChk) frameErr <= (wordNext != leadLen);
    end
  end

  assign rdSt.cntLast4 = (rdCnt == 2'd3);
  assign rdSt.wordZero = (wordNext == 32'd0);
  assign rdSt.remOne   = (rem == 32'd1);
  assign rdSt.leadOdd  = leadLen[0];
endmodule

// File: rtl/tapefr_ctrl.sv
`timescale 1ns/1ps
module tapefr_ctrl
  import tapefr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrValid,
  input  logic      wrLast,
  output logic      wrReady,
  input  logic      markValid,
  output logic      markReady,
  output logic      txValid,
  input  logic      txReady,
  input  wrStatus_t wrSt,
  output wrStrobe_t wrS,
  input  logic      rxValid,
  output logic      rxReady,
  output logic      outValid,
  output logic      outLast,
  input  logic      outReady,
  input  rdStatus_t rdSt,
  output rdStrobe_t rdS
);
  wrState_e wrState, wrNext;
  rdState_e rdState, rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrState <= W_FILL;
      rdState <= R_HEAD;
    end else begin
      wrState <= wrNext;
      rdState <= rdNext;
    end
  end

  // write half: fill buffer, then header, body, pad, trailer; or a mark
  always_comb begin
    wrNext    = wrState;
    wrS       = '0;
    wrS.src   = SRC_ZERO;
    wrReady   = 1'b0;
    markReady = 1'b0;
    txValid   = 1'b0;
    case (wrState)
      W_FILL: begin
        wrReady   = !wrSt.full;
        markReady = wrSt.empty && !wrValid;
        if (wrValid && !wrSt.full) begin
          wrS.store = 1'b1;
          if (wrLast) begin
            wrNext     = W_HEAD;
            wrS.idxClr = 1'b1;
          end
        end else if (markValid && wrSt.empty) begin
          wrNext     = W_MARK;
          wrS.idxClr = 1'b1;
        end
      end
      W_HEAD: begin
        txValid = 1'b1;
        wrS.src = SRC_LEN;
        if (txReady) begin
          if (wrSt.idxLast4) begin
            wrNext     = W_BODY;
            wrS.idxClr = 1'b1;
          end else wrS.idxInc = 1'b1;
        end
      end
      W_BODY: begin
        txValid = 1'b1;
        wrS.src = SRC_BUF;
        if (txReady) begin
          if (wrSt.bodyLast) begin
            wrNext     = wrSt.oddLen ? W_PAD : W_TAIL;
            wrS.idxClr = 1'b1;
          end else wrS.idxInc = 1'b1;
        end
      end
      W_PAD: begin
        txValid = 1'b1;
        wrS.src = SRC_ZERO;
        if (txReady) wrNext = W_TAIL;
      end
      W_TAIL: begin
        txValid = 1'b1;
        wrS.src = SRC_LEN;
        if (txReady) begin
          if (wrSt.idxLast4) begin
            wrNext      = W_FILL;
            wrS.fillClr = 1'b1;
            wrS.idxClr  = 1'b1;
          end else wrS.idxInc = 1'b1;
        end
      end
      W_MARK: begin
        txValid = 1'b1;
        wrS.src = SRC_ZERO;
        if (txReady) begin
          if (wrSt.idxLast4) begin
            wrNext     = W_FILL;
            wrS.idxClr = 1'b1;
          end else wrS.idxInc = 1'b1;
        end
      end
      default: wrNext = W_FILL;
    endcase
  end

  // read half: header word, payload, optional pad, trailer word
  always_comb begin
    rdNext   = rdState;
    rdS      = '0;
    rxReady  = 1'b0;
    outValid = 1'b0;
    outLast  = 1'b0;
    case (rdState)
      R_HEAD: begin
        rxReady = 1'b1;
        if (rxValid) begin
          rdS.shift = 1'b1;
          if (rdSt.cntLast4) begin
            rdS.cntClr = 1'b1;
            if (rdSt.wordZero) rdS.markHit = 1'b1;
            else begin
              rdS.loadLen = 1'b1;
              rdNext      = R_BODY;
            end
          end
        end
      end
      R_BODY: begin
        rxReady  = outReady;
        outValid = rxValid;
        outLast  = rdSt.remOne;
        if (rxValid && outReady) begin
          rdS.remDec = 1'b1;
          if (rdSt.remOne) rdNext = rdSt.leadOdd ? R_PAD : R_TAIL;
        end
      end
      R_PAD: begin
        rxReady = 1'b1;
        if (rxValid) rdNext = R_TAIL;
      end
      R_TAIL: begin
        rxReady = 1'b1;
        if (rxValid) begin
          rdS.shift = 1'b1;
          if (rdSt.cntLast4) begin
            rdS.cntClr  = 1'b1;
            rdS.tailChk = 1'b1;
            rdNext      = R_HEAD;
          end
        end
      end
      default: rdNext = R_HEAD;
    endcase
  end
endmodule

// File: rtl/tape_rec_framer.sv
`timescale 1ns/1ps
module tape_rec_framer
  import tapefr_pkg::*;
#(
  parameter int MAX_BYTES = 2048
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] wrData,
  input  logic       wrValid,
  input  logic       wrLast,
  output logic       wrReady,
  input  logic       markValid,
  output logic       markReady,
  output logic [7:0] txData,
  output logic       txValid,
  input  logic       txReady,
  input  logic [7:0] rxData,
  input  logic       rxValid,
  output logic       rxReady,
  output logic [7:0] outData,
  output logic       outValid,
  output logic       outLast,
  input  logic       outReady,
  output logic       markSeen,
  output logic       eotSeen,
  output logic       frameErr
);
  wrStrobe_t wrS;
  wrStatus_t wrSt;
  rdStrobe_t rdS;
  rdStatus_t rdSt;

  tapefr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrLast(wrLast), .wrReady(wrReady),
    .markValid(markValid), .markReady(markReady),
    .txValid(txValid), .txReady(txReady),
    .wrSt(wrSt), .wrS(wrS),
    .rxValid(rxValid), .rxReady(rxReady),
    .outValid(outValid), .outLast(outLast), .outReady(outReady),
    .rdSt(rdSt), .rdS(rdS)
  );

  tapefr_dp #(.MAX_BYTES(MAX_BYTES)) u_dp (
    .clk(clk), .rstN(rstN),
    .wrData(wrData), .wrS(wrS), .wrSt(wrSt), .txData(txData),
    .rxData(rxData), .rdS(rdS), .rdSt(rdSt),
    .markSeen(markSeen), .eotSeen(eotSeen), .frameErr(frameErr)
  );

  assign outData = rxData;
endmodule

// File: rtl/tape_rec_framer_chk.sv
`timescale 1ns/1ps
module tape_rec_framer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrReady,
  input logic       markReady,
  input logic [7:0] txData,
  input logic       txValid,
  input logic       txReady,
  input logic       rxValid,
  input logic       rxReady,
  input logic       outValid,
  input logic       outReady,
  input logic       markSeen,
  input logic       eotSeen,
  input logic       frameErr
);
  // R2: a stalled stream byte is held unchanged
  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData));

  // R5: no record byte is taken while framing output is in progress
  assert_wr_blocked_R5: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !wrReady);

  // R4: a file mark is never accepted during emission
  assert_mark_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    markReady |-> !txValid);

  // R9: end of data is only reported on a file mark
  assert_eot_on_mark_R9: assert property (@(posedge clk) disable iff (!rstN)
    eotSeen |-> markSeen);

  // R8: a mark indication lasts one cycle
  assert_mark_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    markSeen |=> !markSeen);

  // R7: a framing error indication lasts one cycle
  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr);

  // R10: a held payload byte is not consumed while the output stalls
  assert_rx_backpress_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && rxValid && !outReady |-> !rxReady);
endmodule

bind tape_rec_framer tape_rec_framer_chk u_chk (.*);

// File: tb/tb_tape_rec_framer.sv
`timescale 1ns/1ps
module tb_tape_rec_framer;
  localparam int MAXB = 16;
  typedef logic [7:0] bq_t[$];

  logic       clk = 1'b0, rstN = 1'b0;
  logic [7:0] wrData = '0;
  logic       wrValid = 1'b0, wrLast = 1'b0, wrReady;
  logic       markValid = 1'b0, markReady;
  logic [7:0] txData;
  logic       txValid, txReady = 1'b0;
  logic [7:0] rxData = '0;
  logic       rxValid = 1'b0, rxReady;
  logic [7:0] outData;
  logic       outValid, outLast, outReady = 1'b1;
  logic       markSeen, eotSeen, frameErr;

  tape_rec_framer #(.MAX_BYTES(MAXB)) dut (.*);

  always #10 clk = ~clk;

  int nChk = 0, nBad = 0;
  int markCnt = 0, eotCnt = 0, errCnt = 0;
  bq_t txQ, outQ;
  bit  lastQ[$];

  task automatic check(string req, string what, longint act, longint exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // stream monitor: ready chosen first, then the coming handshake recorded
  always @(negedge clk) begin
    txReady = ($urandom % 4) != 0;
    if (txValid && txReady) txQ.push_back(txData);
    if (markSeen) markCnt++;
    if (eotSeen)  eotCnt++;
    if (frameErr) errCnt++;
  end

  function automatic bq_t frameOf(bq_t pay, logic [7:0] pad, int tailDelta);
    bq_t q;
    int n = pay.size();
    int t = n + tailDelta;
    for (int i = 0; i < 4; i++) q.push_back(8'(n >> (8*i)));
    foreach (pay[i]) q.push_back(pay[i]);
    if (n[0]) q.push_back(pad);
    for (int i = 0; i < 4; i++) q.push_back(8'(t >> (8*i)));
    return q;
  endfunction

  function automatic bq_t randPay(int n);
    bq_t q;
    for (int i = 0; i < n; i++) q.push_back(8'($urandom));
    return q;
  endfunction

  task automatic waitTx(int n);
    for (int k = 0; k < 4000 && txQ.size() < n; k++) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic compareTx(bq_t exp, int n);
    int badHdr = 0, badPay = 0, badPad = 0;
    check("R2", "emitted byte count", txQ.size(), exp.size());
    if (txQ.size() == exp.size()) begin
      foreach (exp[i]) begin
        if (txQ[i] !== exp[i]) begin
          if (i < 4 || i >= exp.size() - 4) badHdr++;
          else if (i < 4 + n) badPay++;
          else badPad++;
        end
      end
      check("R2", "length word byte mismatches", badHdr, 0);
      check("R2", "payload byte mismatches", badPay, 0);
      if (n % 2 == 1) check("R3", "pad byte mismatches", badPad, 0);
    end
  endtask

  task automatic sendByte(logic [7:0] d, bit last);
    @(negedge clk);
    wrValid = 1'b1; wrData = d; wrLast = last;
    while (!wrReady) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic writeRec(bq_t pay);
    txQ.delete();
    foreach (pay[i]) sendByte(pay[i], i == pay.size() - 1);
    @(negedge clk);
    // R5: byte still offered after the last one; must not be taken
    wrData = 8'hEE; wrLast = 1'b1;
    check("R5", "wrReady after last byte", wrReady, 0);
    @(negedge clk);
    wrValid = 1'b0; wrLast = 1'b0;
    waitTx(pay.size() + 8 + (pay.size() % 2));
    compareTx(frameOf(pay, 8'h00, 0), pay.size());
  endtask

  task automatic sendMark();
    txQ.delete();
    @(negedge clk);
    markValid = 1'b1;
    while (!markReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    markValid = 1'b0;
    check("R5", "wrReady during mark", wrReady, 0);
    waitTx(4);
    check("R4", "mark byte count", txQ.size(), 4);
    foreach (txQ[i]) check("R4", "mark byte value", txQ[i], 0);
  endtask

  task automatic sendRx(logic [7:0] b);
    bit done = 1'b0;
    while (!done) begin
      @(negedge clk);
      outReady = ($urandom % 3) != 0;
      rxValid = 1'b1; rxData = b;
      #1;
      if (outValid && outReady) begin
        outQ.push_back(outData);
        lastQ.push_back(outLast);
      end
      if (rxReady) begin
        @(posedge clk);
        done = 1'b1;
      end
    end
  endtask

  task automatic feed(bq_t s);
    foreach (s[i]) sendRx(s[i]);
    @(negedge clk);
    rxValid = 1'b0; outReady = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic checkOut(string req, bq_t expD, bit expL[$]);
    int badD = 0, badL = 0;
    check(req, "delivered byte count", outQ.size(), expD.size());
    if (outQ.size() == expD.size()) begin
      foreach (expD[i]) begin
        if (outQ[i] !== expD[i]) badD++;
        if (lastQ[i] !== expL[i]) badL++;
      end
      check(req, "payload mismatches", badD, 0);
      check("R6", "outLast mismatches", badL, 0);
    end
    outQ.delete(); lastQ.delete();
  endtask

  task automatic expectRec(bq_t pay, ref bq_t d, ref bit l[$]);
    foreach (pay[i]) begin
      d.push_back(pay[i]);
      l.push_back(i == pay.size() - 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    bq_t p, s, expD;
    bit  expL[$];
    int  m0, e0, r0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "wrReady", wrReady, 1);
    check("R1", "markReady", markReady, 1);
    check("R1", "txValid", txValid, 0);
    check("R1", "rxReady", rxReady, 1);
    check("R1", "outValid", outValid, 0);
    check("R1", "pulses", {markSeen, eotSeen, frameErr}, 0);

    // ---- write side: directed lengths
    writeRec(randPay(1));
    writeRec(randPay(2));
    writeRec(randPay(MAXB));
    writeRec(randPay(MAXB - 1));

    // R4: record byte and mark offered together: byte wins
    txQ.delete();
    @(negedge clk);
    wrValid = 1'b1; wrData = 8'h5A; wrLast = 1'b1; markValid = 1'b1;
    #1 check("R4", "markReady with wrValid high", markReady, 0);
    @(posedge clk);
    @(negedge clk);
    wrValid = 1'b0; wrLast = 1'b0; markValid = 1'b0;
    waitTx(10);
    p.delete(); p.push_back(8'h5A);
    compareTx(frameOf(p, 8'h00, 0), 1);

    // R4: mark blocked while a record is partly buffered
    txQ.delete();
    p = randPay(3);
    sendByte(p[0], 1'b0);
    @(negedge clk);
    wrValid = 1'b0;
    #1 check("R4", "markReady with buffered byte", markReady, 0);
    sendByte(p[1], 1'b0);
    sendByte(p[2], 1'b1);
    @(negedge clk);
    wrValid = 1'b0; wrLast = 1'b0;
    waitTx(12);
    compareTx(frameOf(p, 8'h00, 0), 3);

    sendMark();

    // ---- write side: random lengths
    for (int r = 0; r < 10; r++) writeRec(randPay(1 + $urandom % MAXB));

    // ---- read side
    // R6/R3: odd record with a nonzero filler that must be discarded
    expD.delete(); expL.delete();
    p = '{8'h11, 8'h22, 8'h33};
    expectRec(p, expD, expL);
    r0 = errCnt;
    feed(frameOf(p, 8'hA5, 0));
    checkOut("R6", expD, expL);
    check("R7", "frameErr on matching odd record", errCnt - r0, 0);

    expD.delete(); expL.delete();
    p = randPay(4);
    expectRec(p, expD, expL);
    feed(frameOf(p, 8'h00, 0));
    checkOut("R6", expD, expL);

    // R8/R9: two marks in a row
    m0 = markCnt; e0 = eotCnt;
    s.delete();
    repeat (8) s.push_back(8'h00);
    feed(s);
    check("R8", "marks seen", markCnt - m0, 2);
    check("R9", "end-of-data seen", eotCnt - e0, 1);
    check("R8", "payload from marks", outQ.size(), 0);

    // R9: mark after a record is not end of data
    expD.delete(); expL.delete();
    p = randPay(5);
    expectRec(p, expD, expL);
    s = frameOf(p, 8'h00, 0);
    repeat (4) s.push_back(8'h00);
    m0 = markCnt; e0 = eotCnt;
    feed(s);
    checkOut("R6", expD, expL);
    check("R8", "mark after record", markCnt - m0, 1);
    check("R9", "end-of-data after record", eotCnt - e0, 0);

    // R7: trailer differs from header
    expD.delete(); expL.delete();
    p = randPay(6);
    expectRec(p, expD, expL);
    r0 = errCnt;
    feed(frameOf(p, 8'h00, 1));
    checkOut("R6", expD, expL);
    check("R7", "frameErr on mismatch", errCnt - r0, 1);

    // R10: output stalled in the middle of a payload
    s = frameOf('{8'hC1, 8'hC2}, 8'h00, 0);
    for (int i = 0; i < 5; i++) sendRx(s[i]);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      outReady = 1'b0; rxValid = 1'b1; rxData = s[5];
      #1 check("R10", "rxReady while output stalled", rxReady, 0);
    end
    for (int i = 5; i < s.size(); i++) sendRx(s[i]);
    @(negedge clk);
    rxValid = 1'b0; outReady = 1'b1;
    repeat (3) @(negedge clk);
    expD = '{8'hC1, 8'hC2}; expL = '{1'b0, 1'b1};
    checkOut("R10", expD, expL);

    // random records on the read side
    expD.delete(); expL.delete();
    s.delete();
    for (int r = 0; r < 8; r++) begin
      bq_t f;
      p = randPay(1 + $urandom % MAXB);
      expectRec(p, expD, expL);
      f = frameOf(p, 8'($urandom), 0);
      foreach (f[i]) s.push_back(f[i]);
    end
    r0 = errCnt;
    feed(s);
    checkOut("R6", expD, expL);
    check("R7", "frameErr on random good records", errCnt - r0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule